// File: doc/BRIEF.md
# DMA Transfer Counter with Reload

This block holds the transfer counts for the channels of a small DMA controller. Each channel keeps its count in two stages. The setting stage is the value that software writes. The working stage counts down by one for each acknowledged transfer. When the working stage borrows below zero, the channel reaches terminal count: it raises a sticky flag and a one-cycle completion pulse, and it disables itself. At that same moment the setting is reloaded into the working stage.

A count written while the channel runs does not disturb the transfer in progress. It is held in the setting stage and becomes the working count when the run completes, or earlier if software pulses the channel's initialise control. A count written after software has stopped a run part-way is dropped. A count written while the channel is suspended is also dropped. Readback returns the remaining count while the channel runs and the setting at every other time. After terminal count, a read therefore returns the programmed value and not zero.

The default build has four channels. Each channel has a 16-bit count, so a count of N gives N+1 transfers.

Top module: `dma_count_unit`

## Requirements
- R1: After reset every channel is inactive (`active`=0), `tc_flag`=0 and `tc_pulse`=0. Count contents are undefined, or 0000h when ZERO_RST=1.
- R2: A write to an idle channel sets both stages. Readback of that channel then returns the written value.
- R3: With a count of N, the channel accepts exactly N+1 acknowledges. `tc_pulse` is high for exactly the one cycle after the acknowledge that borrows. A count of 0000h gives 1 transfer and FFFFh gives 65536.
- R4: While a channel is active, readback returns the remaining count, which is the written count minus the acknowledges taken so far.
- R5: A write during an active run leaves the remaining count unchanged. At terminal count the written value becomes the working count, so the next run has that length.
- R6: An `init` pulse loads the setting into the working stage, makes the channel inactive and clears `tc_flag`.
- R7: After `enable_clr` stops an active run, a count write is ignored. The setting is unchanged, and a later `enable_set` resumes with the remaining count.
- R8: After terminal count with no rewrite, readback returns the value that was programmed before the run.
- R9: While `suspend` is high for a channel, its acknowledges and its count writes have no effect.
- R10: At terminal count `active` clears by itself and `tc_flag` sets. The flag stays set until `tc_clr` or `enable_set`.
- R11: Acknowledges to an inactive channel change neither its count nor its flags.
- R12: Channels are independent. An acknowledge or a write on one channel does not affect the others.
- R13: A write and an acknowledge in the same cycle both take effect. The write goes to the setting stage and the decrement goes to the working stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Count write strobe |
| wr_ch | input | 2 | Channel selected for the write |
| wr_data | input | 16 | Count value to write |
| rd_ch | input | 2 | Channel selected for readback |
| rd_data | output | 16 | Readback value, combinational |
| enable_set | input | 4 | Per-channel pulse that starts or resumes a run |
| enable_clr | input | 4 | Per-channel pulse that stops a run |
| suspend | input | 4 | Per-channel level that freezes the channel |
| init | input | 4 | Per-channel pulse that loads the setting into the working stage |
| tc_clr | input | 4 | Per-channel pulse that clears the terminal-count flag |
| ack | input | 4 | Per-channel transfer acknowledge |
| active | output | 4 | Channel is enabled and running |
| tc_flag | output | 4 | Sticky terminal-count flag |
| tc_pulse | output | 4 | One-cycle completion pulse |

## Verification
Run lengths are measured for counts of 0, 1, small values and FFFFh on different channels. This shows whether the N+1 encoding and the borrow end condition are right at both extremes. Mid-run readbacks, taken after a same-cycle write and acknowledge, separate the working stage from the setting stage. Separate sequences cover software stop and resume, initialise during a run, and suspension. Each one compares the next run length and the readback against the value a correct reload would give. This shows whether a dropped write really was dropped and whether a queued write really was taken.

// File: rtl/dma_cnt_pkg.sv
package dma_cnt_pkg;
    localparam int DEF_CNT_W = 16;
    localparam int DEF_NCH   = 4;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_ABORT = 2'd2
    } ch_mode_t;
endpackage

// File: rtl/dma_cnt_wdec.sv
module dma_cnt_wdec #(
    parameter int NCH   = 4,
    parameter int SEL_W = 2
) (
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_ch,
    output logic [NCH-1:0]   hit
);
    for (genvar i = 0; i < NCH; i++) begin : g_hit
        assign hit[i] = wr_en && (wr_ch == SEL_W'(i));
    end
endmodule

// File: rtl/dma_cnt_rmux.sv
module dma_cnt_rmux #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16,
    parameter int SEL_W = 2
) (
    input  logic [CNT_W-1:0] vals [NCH],
    input  logic [SEL_W-1:0] sel,
    output logic [CNT_W-1:0] out
);
    always_comb begin
        out = '0;
        for (int i = 0; i < NCH; i++) begin
            if (sel == SEL_W'(i)) out = vals[i];
        end
    end
endmodule

// File: rtl/dma_cnt_chan.sv
module dma_cnt_chan
    import dma_cnt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit ZERO_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             susp,
    input  logic             init,
    input  logic             tc_clr,
    input  logic             ack,
    output logic [CNT_W-1:0] rd_val,
    output logic             active,
    output logic             tc_flag,
    output logic             tc_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] master;
        logic [CNT_W-1:0] slave;
        ch_mode_t         mode;
        logic             tc;
        logic             tcp;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     wr_ok, step_ok, borrow;

    always_comb begin
        st_d    = st_q;
        st_d.tcp = 1'b0;
        wr_ok   = wr_hit && !susp && (st_q.mode != CH_ABORT);
        step_ok = ack && !susp && !init && (st_q.mode == CH_RUN);
        borrow  = step_ok && (st_q.slave == '0);

        if (wr_ok) begin
            st_d.master = wr_data;
            if (st_q.mode == CH_IDLE) st_d.slave = wr_data;
        end

        if (step_ok) begin
            if (borrow) begin
                st_d.slave = wr_ok ? wr_data : st_q.master;
                st_d.mode  = CH_IDLE;
                st_d.tc    = 1'b1;
                st_d.tcp   = 1'b1;
            end else begin
                st_d.slave = st_q.slave - ONE;
            end
        end

        if (init) begin
            st_d.slave = st_d.master;
            st_d.mode  = CH_IDLE;
            st_d.tc    = 1'b0;
        end else if (!borrow) begin
            if (tc_clr) st_d.tc = 1'b0;
            if (en_clr) begin
                if (st_q.mode == CH_RUN) st_d.mode = CH_ABORT;
            end else if (en_set) begin
                st_d.mode = CH_RUN;
                st_d.tc   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.master <= ZERO_RST ? '0 : 'x;
            st_q.slave  <= ZERO_RST ? '0 : 'x;
            st_q.mode   <= CH_IDLE;
            st_q.tc     <= 1'b0;
            st_q.tcp    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = (st_q.mode == CH_RUN);
    assign rd_val   = active ? st_q.slave : st_q.master;
    assign tc_flag  = st_q.tc;
    assign tc_pulse = st_q.tcp;
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit
    import dma_cnt_pkg::*;
#(
    parameter int NCH      = DEF_NCH,
    parameter int CNT_W    = DEF_CNT_W,
    parameter bit ZERO_RST = 1'b0,
    localparam int SEL_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_ch,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_ch,
    output logic [CNT_W-1:0] rd_data,
    input  logic [NCH-1:0]   enable_set,
    input  logic [NCH-1:0]   enable_clr,
    input  logic [NCH-1:0]   suspend,
    input  logic [NCH-1:0]   init,
    input  logic [NCH-1:0]   tc_clr,
    input  logic [NCH-1:0]   ack,
    output logic [NCH-1:0]   active,
    output logic [NCH-1:0]   tc_flag,
    output logic [NCH-1:0]   tc_pulse
);
    logic [NCH-1:0]   wr_hit;
    logic [CNT_W-1:0] rd_vals [NCH];

    dma_cnt_wdec #(.NCH(NCH), .SEL_W(SEL_W)) u_wdec (
        .wr_en (wr_en),
        .wr_ch (wr_ch),
        .hit   (wr_hit)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_cnt_chan #(.CNT_W(CNT_W), .ZERO_RST(ZERO_RST)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit[i]),
            .wr_data  (wr_data),
            .en_set   (enable_set[i]),
            .en_clr   (enable_clr[i]),
            .susp     (suspend[i]),
            .init     (init[i]),
            .tc_clr   (tc_clr[i]),
            .ack      (ack[i]),
            .rd_val   (rd_vals[i]),
            .active   (active[i]),
            .tc_flag  (tc_flag[i]),
            .tc_pulse (tc_pulse[i])
        );
    end

    dma_cnt_rmux #(.NCH(NCH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_rmux (
        .vals (rd_vals),
        .sel  (rd_ch),
        .out  (rd_data)
    );
endmodule

// File: rtl/dma_cnt_checker.sv
module dma_cnt_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] enable_set,
    input logic [NCH-1:0] enable_clr,
    input logic [NCH-1:0] suspend,
    input logic [NCH-1:0] init,
    input logic [NCH-1:0] active,
    input logic [NCH-1:0] tc_flag,
    input logic [NCH-1:0] tc_pulse
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[i] |=> !tc_pulse[i]); // R3
        AST_TC_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[i] |-> !active[i]); // R10
        AST_TC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[i] |-> tc_flag[i]); // R10
        AST_TC_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tc_pulse[i]) |-> $past(active[i])); // R11
        AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (suspend[i] && !enable_set[i] && !enable_clr[i] && !init[i])
            |=> $stable(active[i])); // R9
    end
endmodule

bind dma_count_unit dma_cnt_checker #(.NCH(NCH)) u_dma_cnt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_set (enable_set),
    .enable_clr (enable_clr),
    .suspend    (suspend),
    .init       (init),
    .active     (active),
    .tc_flag    (tc_flag),
    .tc_pulse   (tc_pulse)
);

// File: tb/dma_count_unit_bench.sv
`timescale 1ns/1ps
module dma_count_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_ch = '0;
    logic [15:0] rd_data;
    logic [3:0]  enable_set = '0, enable_clr = '0, suspend = '0;
    logic [3:0]  init = '0, tc_clr = '0, ack = '0;
    logic [3:0]  active, tc_flag, tc_pulse;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dma_count_unit u_dma_count_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
        .rd_ch(rd_ch), .rd_data(rd_data), .enable_set(enable_set),
        .enable_clr(enable_clr), .suspend(suspend), .init(init), .tc_clr(tc_clr),
        .ack(ack), .active(active), .tc_flag(tc_flag), .tc_pulse(tc_pulse)
    );

    // {channel, count}
    localparam logic [17:0] VEC [5] = '{
        {2'd0, 16'h0000},
        {2'd1, 16'h0001},
        {2'd2, 16'h0005},
        {2'd3, 16'h0025},
        {2'd0, 16'h0003}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] ch, input logic [15:0] v);
        wr_en = 1'b1; wr_ch = ch; wr_data = v;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic pulse_en(input int ch);
        enable_set[ch] = 1'b1;
        cyc();
        enable_set[ch] = 1'b0;
    endtask

    task automatic acks(input int ch, input int k);
        ack[ch] = 1'b1;
        repeat (k) cyc();
        ack[ch] = 1'b0;
    endtask

    task automatic rd(input logic [1:0] ch, output logic [15:0] v);
        rd_ch = ch;
        #1;
        v = rd_data;
    endtask

    task automatic run_to_tc(input int ch, output int n);
        n = 0;
        ack[ch] = 1'b1;
        while (n < 70000) begin
            cyc();
            n++;
            if (tc_pulse[ch]) break;
        end
        ack[ch] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL R3 watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) cyc();
        // R1 reset state
        chk("R1 active", 32'(active), 32'h0);
        chk("R1 tc_flag", 32'(tc_flag), 32'h0);
        chk("R1 tc_pulse", 32'(tc_pulse), 32'h0);
        rst_n = 1'b1;
        cyc();

        // table walk: run lengths (R3), readback of setting after TC (R8)
        foreach (VEC[i]) begin
            int ch = int'(VEC[i][17:16]);
            logic [15:0] cnt = VEC[i][15:0];
            wr(VEC[i][17:16], cnt);
            rd(VEC[i][17:16], v);
            chk("R2 idle write readback", 32'(v), 32'(cnt));
            pulse_en(ch);
            chk("R12 only selected channel active", 32'(active), 32'(4'b1 << ch));
            run_to_tc(ch, n);
            chk("R3 run length", 32'(n), 32'(cnt) + 1);
            chk("R10 auto disable", 32'(active[ch]), 32'h0);
            chk("R10 flag set", 32'(tc_flag[ch]), 32'h1);
            rd(VEC[i][17:16], v);
            chk("R8 readback after tc", 32'(v), 32'(cnt));
            cyc();
            chk("R3 pulse one cycle", 32'(tc_pulse[ch]), 32'h0);
            chk("R10 flag sticky", 32'(tc_flag[ch]), 32'h1);
            tc_clr[ch] = 1'b1; cyc(); tc_clr[ch] = 1'b0;
            chk("R10 flag cleared", 32'(tc_flag[ch]), 32'h0);
        end

        // R4, R13, R5 on channel 0
        wr(2'd0, 16'd10);
        pulse_en(0);
        acks(0, 3);
        rd(2'd0, v);
        chk("R4 remaining count", 32'(v), 32'd7);
        ack[0] = 1'b1; wr(2'd0, 16'd20); ack[0] = 1'b0;
        rd(2'd0, v);
        chk("R13 decrement with write", 32'(v), 32'd6);
        run_to_tc(0, n);
        chk("R5 run unchanged by queued write", 32'(n), 32'd7);
        rd(2'd0, v);
        chk("R5 queued value visible", 32'(v), 32'd20);
        // R11 acks while idle
        acks(0, 4);
        rd(2'd0, v);
        chk("R11 idle ack no count change", 32'(v), 32'd20);
        chk("R11 idle ack no pulse", 32'(tc_pulse[0]), 32'h0);
        chk("R11 idle ack flag held", 32'(tc_flag[0]), 32'h1);
        pulse_en(0);
        chk("R10 enable clears flag", 32'(tc_flag[0]), 32'h0);
        run_to_tc(0, n);
        chk("R5 next run uses queued count", 32'(n), 32'd21);

        // R9 suspend on channel 1
        wr(2'd1, 16'd5);
        pulse_en(1);
        suspend[1] = 1'b1;
        acks(1, 3);
        wr(2'd1, 16'h0099);
        rd(2'd1, v);
        chk("R9 suspended ack ignored", 32'(v), 32'd5);
        suspend[1] = 1'b0;
        run_to_tc(1, n);
        chk("R9 run after suspend", 32'(n), 32'd6);
        rd(2'd1, v);
        chk("R9 suspended write ignored", 32'(v), 32'd5);

        // R7 stop, write, resume on channel 2
        wr(2'd2, 16'd8);
        pulse_en(2);
        acks(2, 2);
        enable_clr[2] = 1'b1; cyc(); enable_clr[2] = 1'b0;
        chk("R7 stopped", 32'(active[2]), 32'h0);
        wr(2'd2, 16'h0033);
        rd(2'd2, v);
        chk("R7 write after stop ignored", 32'(v), 32'd8);
        pulse_en(2);
        rd(2'd2, v);
        chk("R7 resume remaining", 32'(v), 32'd6);
        run_to_tc(2, n);
        chk("R7 resumed run length", 32'(n), 32'd7);
        rd(2'd2, v);
        chk("R7 setting kept", 32'(v), 32'd8);

        // R6 init on channel 3
        wr(2'd3, 16'd9);
        pulse_en(3);
        acks(3, 4);
        wr(2'd3, 16'd2);
        rd(2'd3, v);
        chk("R6 before init remaining", 32'(v), 32'd5);
        init[3] = 1'b1; cyc(); init[3] = 1'b0;
        chk("R6 init stops channel", 32'(active[3]), 32'h0);
        chk("R6 init clears flag", 32'(tc_flag[3]), 32'h0);
        pulse_en(3);
        run_to_tc(3, n);
        chk("R6 run after init", 32'(n), 32'd3);
        rd(2'd0, v);
        chk("R12 other channel untouched", 32'(v), 32'd20);

        // R3 maximum count
        wr(2'd2, 16'hFFFF);
        pulse_en(2);
        run_to_tc(2, n);
        chk("R3 max count length", 32'(n), 32'd65536);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule